// File: doc/BRIEF.md
# Input Port Change Detector

This block watches a small group of general-purpose input pins, four by default. Each pin is brought into the clock domain through a flop chain. The block keeps a sticky flag per pin that records whether the synchronised level has moved since software last looked. One status word places the live levels in its low half and the change flags in its high half.

A read strobe marks the cycle in which the status word is taken, and that read clears the flags. A per-pin enable nibble is written through a control byte that shares the status word's address, with write direction only. The enabled flags are ORed into one summary interrupt line. The wider interrupt controller can use that line as its input-change source.

Top module: `ipc_change_detect`

## Requirements
- R1: While reset is asserted, and until the first input change after it, `stat_o` reads all zeros and `irq_o` is low. The enable nibble resets to zero.
- R2: Bit i of `stat_o` (i = 0..3) shows the level of `pin_i[i]`. The level is sampled at the rising edge where the input is captured and becomes visible after the second rising edge.
- R3: Bit 4+i of `stat_o` sets when the synchronised level of `pin_i[i]` changes, on rising or falling transitions alike. It becomes visible one clock after the new level shows in bit i.
- R4: A change flag stays set until a cycle in which `stat_rd_i` is high. It clears at the clock edge that ends that cycle. During the read cycle, `stat_o` still shows the flags.
- R5: If a synchronised change on pin i falls in the same cycle as the clearing read, flag i stays set after the read.
- R6: A cycle with `ctl_wr_i` high loads enable bit i from `ctl_wdata_i[i]` for i = 0..3. Bits 7..4 of `ctl_wdata_i` have no effect. Without a write, the enables hold.
- R7: `irq_o` is high exactly when at least one change flag is set whose enable bit is also set. A flag whose enable is clear does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 4 | Asynchronous input pins |
| ctl_wr_i | input | 1 | Write strobe for the control byte |
| ctl_wdata_i | input | 8 | Control byte; bits 3..0 are the per-pin enables |
| stat_rd_i | input | 1 | Read strobe for the status word; clears the flags |
| stat_o | output | 8 | {change flags 3..0, live levels 3..0} |
| irq_o | output | 1 | Summary input-change interrupt |

## Verification
The assertions check three things on every cycle. A synchronised edge always sets its flag. A flag never drops without a read, and a read clears every flag that has no concurrent edge. The enables move only on a write, and the interrupt never rises with all enables clear. The bench's scenarios are needed to show the rest. Those are the exact latency from pin to level and from pin to flag, the survival of a flag whose edge coincides with the read, the masking of upper control bits, and the interrupt's match to the masked flags under random pin, read and write traffic.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int unsigned IPC_PINS_DEF = 4;
  localparam int unsigned IPC_CTL_W    = 8;
  localparam int unsigned IPC_SYNC_DEF = 2;

  function automatic logic [2*IPC_PINS_DEF-1:0] ipc_pack_status(
      input logic [IPC_PINS_DEF-1:0] flags,
      input logic [IPC_PINS_DEF-1:0] levels);
    return {flags, levels};
  endfunction
endpackage

// File: rtl/ipc_rst_sync.sv
module ipc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end

  assign rst_n_o = rst_q[1];
endmodule

// File: rtl/ipc_sync.sv
module ipc_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb chain_d = {chain_q[STAGES-2:0], d_i[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign q_o[g] = chain_q[LAST];
  end
endmodule

// File: rtl/ipc_flags.sv
module ipc_flags #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] flag_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] edge_w;
  logic [WIDTH-1:0] flag_d;
  logic [WIDTH-1:0] flag_q;

  always_comb begin
    edge_w = level_i ^ prev_q;
    // a concurrent edge wins over the clearing read
    flag_d = edge_w | (flag_q & {WIDTH{~rd_i}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= level_i;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  a_r3_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_w) |=> ((flag_q & $past(edge_w)) == $past(edge_w)));

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> ((flag_q & ~$past(edge_w)) == '0));
endmodule

// File: rtl/ipc_change_detect.sv
module ipc_change_detect #(
  parameter int unsigned PINS   = ipc_pkg::IPC_PINS_DEF,
  parameter int unsigned STAGES = ipc_pkg::IPC_SYNC_DEF,
  parameter int unsigned CTL_W  = ipc_pkg::IPC_CTL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PINS-1:0]   pin_i,
  input  logic              ctl_wr_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  input  logic              stat_rd_i,
  output logic [2*PINS-1:0] stat_o,
  output logic              irq_o
);
  logic            rst_int_n;
  logic [PINS-1:0] level_w;
  logic [PINS-1:0] flag_w;
  logic [PINS-1:0] en_q;
  logic [PINS-1:0] en_d;

  ipc_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_int_n)
  );

  ipc_sync #(.WIDTH(PINS), .STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (pin_i),
    .q_o   (level_w)
  );

  ipc_flags #(.WIDTH(PINS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .level_i (level_w),
    .rd_i    (stat_rd_i),
    .flag_o  (flag_w)
  );

  always_comb begin
    en_d = en_q;
    if (ctl_wr_i) en_d = ctl_wdata_i[PINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) en_q <= '0;
    else            en_q <= en_d;
  end

  assign stat_o = {flag_w, level_w};
  assign irq_o  = |(flag_w & en_q);

  a_r6_enable_holds: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ctl_wr_i |=> $stable(en_q));

  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o |-> (|en_q));

  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o |-> (|stat_o[2*PINS-1:PINS]));
endmodule

// File: tb/ipc_change_detect_tb.sv
module ipc_change_detect_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] pin_i;
  logic       ctl_wr_i;
  logic [7:0] ctl_wdata_i;
  logic       stat_rd_i;
  logic [7:0] stat_o;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [3:0] m_s1, m_lvl, m_prev, m_flag, m_en;

  always #4 clk = ~clk;

  ipc_change_detect u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .ctl_wr_i(ctl_wr_i),
    .ctl_wdata_i(ctl_wdata_i), .stat_rd_i(stat_rd_i),
    .stat_o(stat_o), .irq_o(irq_o)
  );

  function automatic logic exp_irq(input logic [3:0] f, input logic [3:0] e);
    return |(f & e);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // inputs were driven at a falling edge; advance one rising edge and compare
  task automatic step();
    logic [3:0] nflag;
    @(posedge clk);
    nflag  = (m_lvl ^ m_prev) | (m_flag & {4{~stat_rd_i}});
    m_prev = m_lvl;
    m_lvl  = m_s1;
    m_s1   = pin_i;
    m_flag = nflag;
    if (ctl_wr_i) m_en = ctl_wdata_i[3:0];
    @(negedge clk);
    check("R2 levels", {4'h0, stat_o[3:0]}, {4'h0, m_lvl});
    check("R3/R4 flags", {4'h0, stat_o[7:4]}, {4'h0, m_flag});
    check("R7 irq", {7'h0, irq_o}, {7'h0, exp_irq(m_flag, m_en)});
  endtask

  task automatic drive(input logic [3:0] p, input logic rd, input logic wr, input logic [7:0] wd);
    pin_i = p; stat_rd_i = rd; ctl_wr_i = wr; ctl_wdata_i = wd;
    step();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [3:0] p;
    void'($urandom(32'h1CE5));
    rst_n = 1'b0; pin_i = '0; ctl_wr_i = 1'b0; ctl_wdata_i = '0; stat_rd_i = 1'b0;
    m_s1 = '0; m_lvl = '0; m_prev = '0; m_flag = '0; m_en = '0;
    repeat (3) @(negedge clk);
    check("R1 reset stat", stat_o, 8'h00);
    check("R1 reset irq", {7'h0, irq_o}, 8'h00);
    rst_n = 1'b1;
    repeat (4) step();
    check("R1 after release", stat_o, 8'h00);

    // R2/R3: latency of a rising change on pin 0
    drive(4'h1, 0, 0, 8'h00);
    check("R2 not yet", {4'h0, stat_o[3:0]}, 8'h00);
    drive(4'h1, 0, 0, 8'h00);
    check("R2 level after two edges", {4'h0, stat_o[3:0]}, 8'h01);
    check("R3 flag not yet", {4'h0, stat_o[7:4]}, 8'h00);
    drive(4'h1, 0, 0, 8'h00);
    check("R3 flag set", stat_o, 8'h11);
    check("R7 disabled no irq", {7'h0, irq_o}, 8'h00);

    // R6: upper control bits ignored
    drive(4'h1, 0, 1, 8'hF0);
    check("R6 upper bits no effect", {7'h0, irq_o}, 8'h00);
    drive(4'h1, 0, 1, 8'hF1);
    check("R7 irq enabled", {7'h0, irq_o}, 8'h01);

    // R4: sticky then cleared by read
    repeat (3) drive(4'h1, 0, 0, 8'h00);
    check("R4 sticky", stat_o, 8'h11);
    drive(4'h1, 1, 0, 8'h00);
    check("R4 cleared by read", stat_o, 8'h01);
    check("R4 irq drops", {7'h0, irq_o}, 8'h00);

    // R3: falling edge also sets
    repeat (3) drive(4'h0, 0, 0, 8'h00);
    check("R3 falling edge", stat_o, 8'h10);

    // R5: edge coincides with read
    drive(4'h4, 0, 0, 8'h00);
    drive(4'h4, 0, 0, 8'h00);
    drive(4'h4, 1, 0, 8'h00);
    check("R5 edge during read kept", stat_o, 8'h44);
    drive(4'h4, 1, 0, 8'h00);
    check("R5 next read clears", stat_o, 8'h04);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      p = pin_i;
      if ($urandom_range(0, 3) == 0) p = 4'($urandom);
      drive(p, $urandom_range(0, 5) == 0, $urandom_range(0, 19) == 0, 8'($urandom));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule